// File: doc/BRIEF.md
# SMBus Host Controller

A byte-wide register file drives a single-master SMBus/I2C engine. Software loads a slave address (with a direction bit), a command byte and, if needed, one data byte. It then writes the control register with a protocol code and the start bit. The engine generates START, address, data, acknowledge, repeated START and STOP on open-drain SCL and SDA. A byte received from the slave is written into the command register or the data0 register, depending on the protocol. The result is reported through sticky status flags that software clears by writing ones to them.

Four protocols are supported: send byte, receive byte, write byte-data and read byte-data. SCL is derived from the system clock. Each bit period is four quarter phases, and each quarter lasts `QDIV` system clocks. An optional watchdog, counted in bit periods, aborts a transaction that runs too long.

Top module: `smbus_host`

## Requirements
- R1: After reset, every readable register reads 0x00 and neither bus line is driven low.
- R2: The register offsets are: 0 status, 1 control, 2 address, 3 command, 4 data0, 5 timeout limit. Offsets 6 and 7 read 0x00. Control bits [4:2] hold the protocol code and read back. Control bit 6 is the start bit and always reads 0.
- R3: Status bit 0 reads 1 from the start of a transaction until its STOP completes. Writes to bit 0 have no effect.
- R4: Protocol code 001 with address bit 0 = 0 (send byte) sends START, then {addr[7:1],0}, then the command byte, then STOP.
- R5: Protocol code 001 with address bit 0 = 1 (receive byte) sends {addr[7:1],1}, reads one byte, NACKs it and stores it in the command register.
- R6: Protocol code 010 with address bit 0 = 0 (write byte-data) sends {addr[7:1],0}, then the command byte, then the data0 byte.
- R7: Protocol code 010 with address bit 0 = 1 (read byte-data) sends {addr[7:1],0} and the command byte, then a repeated START and {addr[7:1],1}. It reads one byte, NACKs it and stores it in data0, leaving the command register unchanged.
- R8: A transaction in which every acknowledge is received ends with status 0x02 (bit 1 = done). Status bits [4:1] clear only where a 1 is written.
- R9: A missing ACK sets status bit 2 instead of bit 1, ends with STOP and stores no received byte.
- R10: If the timeout register is nonzero, the transaction is aborted once that many bit periods have completed. The abort sets status bit 3, clears busy and releases both lines.
- R11: A start with a protocol code other than 001 or 010 sets status bit 4 and causes no bus activity.
- R12: While busy, a further start is ignored, and writes to the control, address, command, data0 and timeout registers are ignored.
- R13: SDA changes only while SCL is low, except at START and STOP. SCL stays high for 2*QDIV clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_sel |
| sda_in | input | 1 | Sensed SDA line level (synchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
If the step sequencer holds a wrong step index or phase, the bench's slave model shows it within one bit period, typically 4*QDIV clocks. It appears as a wrong START/STOP count, a byte stored at the wrong pointer, or a result that lands in the wrong register. A stale error flag or a lost done pulse shows up at the status register as soon as the busy bit drops. An SDA edge while SCL is high would be seen by the slave as a spurious START or STOP and would corrupt that same transaction.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CTL  = 3'd1;
  localparam logic [2:0] OFS_ADR  = 3'd2;
  localparam logic [2:0] OFS_CMD  = 3'd3;
  localparam logic [2:0] OFS_DAT  = 3'd4;
  localparam logic [2:0] OFS_TLIM = 3'd5;

  localparam int unsigned CTL_GO = 6;

  localparam logic [2:0] PR_SHORT    = 3'b001;
  localparam logic [2:0] PR_BYTEDATA = 3'b010;

  typedef enum logic [2:0] {
    K_START, K_TXA_W, K_TXA_R, K_TXC, K_TXD, K_RX, K_STOP
  } kind_e;

  // Step list per protocol; rd is the direction bit of the address register
  function automatic kind_e step_kind(logic [2:0] proto, logic rd, logic [2:0] idx);
    kind_e k;
    k = K_STOP;
    if (proto == PR_SHORT) begin
      case (idx)
        3'd0: k = K_START;
        3'd1: k = rd ? K_TXA_R : K_TXA_W;
        3'd2: k = rd ? K_RX : K_TXC;
        default: k = K_STOP;
      endcase
    end else begin
      case (idx)
        3'd0: k = K_START;
        3'd1: k = K_TXA_W;
        3'd2: k = K_TXC;
        3'd3: k = rd ? K_START : K_TXD;
        3'd4: k = rd ? K_TXA_R : K_STOP;
        3'd5: k = rd ? K_RX : K_STOP;
        default: k = K_STOP;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/smbh_tick.sv
module smbh_tick #(
  parameter int unsigned QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cnt_q == LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R13: quarter ticks never come closer than QDIV clocks
  a_r13_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && QDIV > 1) |=> !tick);
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       tick,
  input  logic [2:0] proto,
  input  logic [7:0] adr,
  input  logic [7:0] cmd,
  input  logic [7:0] dat,
  input  logic [7:0] tlim,
  input  logic       sda_in,
  output logic       busy,
  output logic       done_p,
  output logic       nack_p,
  output logic       tmo_p,
  output logic       rx_p,
  output logic [7:0] rx_byte,
  output logic       scl_low,
  output logic       sda_low
);
  logic       busy_q, busy_n;
  logic [2:0] idx_q, idx_n;
  logic [1:0] ph_q, ph_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic       stop_q, stop_n;
  logic       nack_q, nack_n;
  logic [7:0] tcnt_q, tcnt_n;
  logic       scl_q, sda_q, bstep_q;
  logic       dscl, dsda;

  kind_e      kind;
  logic       is_tx, is_rx, is_bit;
  logic [7:0] txb;

  assign kind   = stop_q ? K_STOP : step_kind(proto, adr[0], idx_q);
  assign is_tx  = kind inside {K_TXA_W, K_TXA_R, K_TXC, K_TXD};
  assign is_rx  = (kind == K_RX);
  assign is_bit = is_tx || is_rx;

  always_comb begin
    case (kind)
      K_TXA_W: txb = {adr[7:1], 1'b0};
      K_TXA_R: txb = {adr[7:1], 1'b1};
      K_TXD:   txb = dat;
      default: txb = cmd;
    endcase
  end

  // line levels for the current phase; registered below
  always_comb begin
    dscl = 1'b0;
    dsda = 1'b0;
    if (busy_q) begin
      case (kind)
        K_START: begin dscl = (ph_q == 2'd0) || (ph_q == 2'd3); dsda = ph_q[1]; end
        K_STOP:  begin dscl = (ph_q == 2'd0); dsda = !ph_q[1]; end
        default: begin
          dscl = (ph_q == 2'd0) || (ph_q == 2'd3);
          dsda = is_tx && (bit_q < 4'd8) && !txb[3'd7 - bit_q[2:0]];
        end
      endcase
    end
  end

  always_comb begin
    busy_n = busy_q; idx_n = idx_q; ph_n = ph_q; bit_n = bit_q; sh_n = sh_q;
    stop_n = stop_q; nack_n = nack_q; tcnt_n = tcnt_q;
    done_p = 1'b0; nack_p = 1'b0; tmo_p = 1'b0; rx_p = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_n = 1'b1; idx_n = '0; ph_n = '0; bit_n = '0;
        stop_n = 1'b0; nack_n = 1'b0; tcnt_n = '0;
      end
    end else if (tick) begin
      ph_n = ph_q + 2'd1;
      if (ph_q == 2'd2 && is_bit) begin
        if (is_rx && bit_q < 4'd8)             sh_n = {sh_q[6:0], sda_in};
        if (is_tx && bit_q == 4'd8 && sda_in)  nack_n = 1'b1;
      end
      if (ph_q == 2'd3) begin
        tcnt_n = tcnt_q + 8'd1;
        if (tlim != 8'd0 && tcnt_n == tlim) begin
          busy_n = 1'b0;
          tmo_p  = 1'b1;
        end else begin
          case (kind)
            K_START: idx_n = idx_q + 3'd1;
            K_STOP: begin
              busy_n = 1'b0;
              if (nack_q) nack_p = 1'b1;
              else        done_p = 1'b1;
            end
            default: begin
              if (bit_q == 4'd8) begin
                bit_n = '0;
                if (is_rx)  rx_p = 1'b1;
                if (nack_q) stop_n = 1'b1;
                else        idx_n = idx_q + 3'd1;
              end else begin
                bit_n = bit_q + 4'd1;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; idx_q <= '0; ph_q <= '0; bit_q <= '0; sh_q <= '0;
      stop_q <= 1'b0; nack_q <= 1'b0; tcnt_q <= '0;
      scl_q <= 1'b0; sda_q <= 1'b0; bstep_q <= 1'b0;
    end else begin
      busy_q <= busy_n; idx_q <= idx_n; ph_q <= ph_n; bit_q <= bit_n; sh_q <= sh_n;
      stop_q <= stop_n; nack_q <= nack_n; tcnt_q <= tcnt_n;
      scl_q <= dscl; sda_q <= dsda; bstep_q <= busy_q && is_bit;
    end
  end

  assign busy    = busy_q;
  assign rx_byte = sh_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;

  // R13: inside a data/ack bit, SDA holds while SCL is released
  a_r13_sda_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bstep_q && $past(bstep_q) && !scl_q && $past(!scl_q)) |-> $stable(sda_q));
  // R1: idle for two cycles means both lines released
  a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> (!scl_q && !sda_q));
  // R10: abort releases the bus two cycles later
  a_r10_tmo_release: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_p |=> ##1 (!scl_q && !sda_q));
endmodule

// File: rtl/smbus_host.sv
module smbus_host
  import smbh_pkg::*;
#(
  parameter int unsigned QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [4:1] st_q, st_d;
  logic [2:0] proto_q, proto_d;
  logic [7:0] adr_q, adr_d, cmd_q, cmd_d, dat_q, dat_d, tlim_q, tlim_d;
  logic       busy, tick, done_p, nack_p, tmo_p, rx_p;
  logic [7:0] rx_byte;
  logic       start_req, code_ok, go, bad;
  logic [4:1] clr;

  assign start_req = reg_wr && (reg_sel == OFS_CTL) && reg_wdata[CTL_GO];
  assign code_ok   = (reg_wdata[4:2] == PR_SHORT) || (reg_wdata[4:2] == PR_BYTEDATA);
  assign go        = start_req && !busy && code_ok;
  assign bad       = start_req && !busy && !code_ok;
  assign clr       = (reg_wr && reg_sel == OFS_STAT) ? reg_wdata[4:1] : 4'd0;

  always_comb begin
    proto_d = proto_q; adr_d = adr_q; cmd_d = cmd_q; dat_d = dat_q; tlim_d = tlim_q;
    st_d = (st_q & ~clr) | {bad, tmo_p, nack_p, done_p};
    if (!busy && reg_wr) begin
      case (reg_sel)
        OFS_CTL:  proto_d = reg_wdata[4:2];
        OFS_ADR:  adr_d   = reg_wdata;
        OFS_CMD:  cmd_d   = reg_wdata;
        OFS_DAT:  dat_d   = reg_wdata;
        OFS_TLIM: tlim_d  = reg_wdata;
        default: ;
      endcase
    end
    if (rx_p) begin
      if (proto_q == PR_SHORT) cmd_d = rx_byte;
      else                     dat_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= '0; proto_q <= '0; adr_q <= '0; cmd_q <= '0; dat_q <= '0; tlim_q <= '0;
    end else begin
      st_q <= st_d; proto_q <= proto_d; adr_q <= adr_d;
      cmd_q <= cmd_d; dat_q <= dat_d; tlim_q <= tlim_d;
    end
  end

  always_comb begin
    case (reg_sel)
      OFS_STAT: reg_rdata = {3'b000, st_q, busy};
      OFS_CTL:  reg_rdata = {3'b000, proto_q, 2'b00};
      OFS_ADR:  reg_rdata = adr_q;
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_DAT:  reg_rdata = dat_q;
      OFS_TLIM: reg_rdata = tlim_q;
      default:  reg_rdata = 8'h00;
    endcase
  end

  smbh_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(srst_n), .run(busy), .tick(tick)
  );

  smbh_seq u_seq (
    .clk(clk), .rst_n(srst_n), .go(go), .tick(tick), .proto(proto_q),
    .adr(adr_q), .cmd(cmd_q), .dat(dat_q), .tlim(tlim_q), .sda_in(sda_in),
    .busy(busy), .done_p(done_p), .nack_p(nack_p), .tmo_p(tmo_p),
    .rx_p(rx_p), .rx_byte(rx_byte), .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );

  // R3: an accepted start makes the engine busy on the next cycle
  a_r3_go_busy: assert property (@(posedge clk) disable iff (!srst_n)
    go |=> busy);
  // R11: a bad code raises bit 4 and starts nothing
  a_r11_bad_code: assert property (@(posedge clk) disable iff (!srst_n)
    bad |=> (st_q[4] && !busy));
  // R12: command register frozen against writes while busy
  a_r12_cmd_frozen: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !rx_p && reg_wr && reg_sel == OFS_CMD) |=> $stable(cmd_q));
  // R8: done and a missing-ACK error never rise together
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(st_q[1]) |-> !$rose(st_q[2]));
endmodule

// File: tb/test_smbus_host.sv
`timescale 1ns/1ps
module test_smbus_host;
  localparam int unsigned QDIV = 4;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic scl_low, sda_low;
  logic s_low = 1'b0;
  wire  scl_w = !scl_low;
  wire  sda_w = !(sda_low | s_low);

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  smbus_host #(.QDIV(QDIV)) i_smbus_host (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_w),
    .scl_drive_low(scl_low), .sda_drive_low(sda_low)
  );

  // ---------------- slave model ----------------
  logic [7:0] slv_mem [256];
  logic [7:0] slv_ptr = 8'h00;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'h00;
  int s_mode = 0, s_cnt = 0, s_widx = 0;
  logic [7:0] s_sh = 8'h00, s_tx = 8'h00;
  logic s_fresh = 1'b0, s_rw = 1'b0, s_mack = 1'b0;
  int n_start = 0, n_stop = 0;
  realtime hi_t0 = 0.0, hi_len = 0.0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    n_start++; s_mode = 1; s_cnt = 0; s_fresh = 1'b1; s_low = 1'b0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    n_stop++; s_mode = 0; s_low = 1'b0;
  end
  always @(posedge scl_w) begin
    hi_t0 = $realtime;
    if ((s_mode == 1 || s_mode == 2) && s_cnt < 8) s_sh = {s_sh[6:0], sda_w};
    else if (s_mode == 3 && s_cnt == 8) s_mack = !sda_w;
  end
  always @(negedge scl_w) begin
    hi_len = $realtime - hi_t0;
    if (s_fresh) s_fresh = 1'b0;
    else if (s_mode != 0) begin
      if (s_cnt < 8) begin
        s_cnt++;
        if (s_cnt < 8) begin
          if (s_mode == 3) s_low = !s_tx[7 - s_cnt];
        end else begin
          case (s_mode)
            1: if (s_sh[7:1] == SLV) begin s_low = 1'b1; s_rw = s_sh[0]; end
               else begin s_mode = 0; s_low = 1'b0; end
            2: begin
                 s_low = 1'b1;
                 if (s_widx == 0) slv_ptr = s_sh; else slv_mem[slv_ptr] = s_sh;
                 s_widx++;
               end
            default: s_low = 1'b0;
          endcase
        end
      end else begin
        s_cnt = 0; s_low = 1'b0;
        if (s_mode == 1) begin
          if (s_rw) begin s_mode = 3; s_tx = slv_mem[slv_ptr]; s_low = !s_tx[7]; end
          else begin s_mode = 2; s_widx = 0; end
        end else if (s_mode == 3) begin
          if (s_mack) begin slv_ptr++; s_tx = slv_mem[slv_ptr]; s_low = !s_tx[7]; end
          else s_mode = 0;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, s);
      if (s[0] == 1'b0) return;
    end
    check("R3 busy never cleared", 1, 0);
  endtask

  function automatic logic [7:0] seed_val(int i);
    return 8'(i * 7 + 3);
  endfunction

  // kind: 0 send byte, 1 receive byte, 2 write byte-data, 3 read byte-data
  task automatic run_op(int kind, logic [6:0] a, logic [7:0] p, logic [7:0] d);
    logic [7:0] s, r;
    logic ack, rdb;
    ack = (a == SLV);
    rdb = (kind == 1 || kind == 3);
    n_start = 0; n_stop = 0;
    wr(3'd2, {a, rdb});
    wr(3'd3, p);
    wr(3'd4, d);
    wr(3'd1, 8'h40 | (((kind < 2) ? 8'd1 : 8'd2) << 2));
    wait_idle();
    rd(3'd0, s);
    if (ack) begin
      check("R8 done status", s, 8'h02);
      case (kind)
        0: begin exp_ptr = p; check("R4 send byte pointer", slv_ptr, exp_ptr); end
        1: begin rd(3'd3, r); check("R5 receive byte into command", r, exp_mem[exp_ptr]); end
        2: begin exp_ptr = p; exp_mem[p] = d; check("R6 write byte-data", slv_mem[p], d); end
        default: begin
          exp_ptr = p;
          rd(3'd4, r); check("R7 read byte-data into data0", r, exp_mem[p]);
          rd(3'd3, r); check("R7 command unchanged", r, p);
        end
      endcase
      check("R7 START count", n_start, (kind == 3) ? 2 : 1);
    end else begin
      check("R9 missing ACK status", s, 8'h04);
      if (kind == 1) begin rd(3'd3, r); check("R9 command not overwritten", r, p); end
      if (kind == 3) begin rd(3'd4, r); check("R9 data0 not overwritten", r, d); end
    end
    check("R13 one STOP", n_stop, 1);
    check("R9 lines released", {scl_low, sda_low}, 2'b00);
    wr(3'd0, s);
    rd(3'd0, s);
    check("R8 write-back clears status", s, 8'h00);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      slv_mem[i] = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int o = 0; o < 8; o++) begin
      rd(3'(o), v); check("R1 reset register value", v, 8'h00);
    end
    check("R1 lines released at reset", {scl_low, sda_low}, 2'b00);

    // R2 register map
    wr(3'd2, 8'hA5); rd(3'd2, v); check("R2 address reg", v, 8'hA5);
    wr(3'd3, 8'h3C); rd(3'd3, v); check("R2 command reg", v, 8'h3C);
    wr(3'd4, 8'hC3); rd(3'd4, v); check("R2 data0 reg", v, 8'hC3);
    wr(3'd5, 8'h11); rd(3'd5, v); check("R2 timeout reg", v, 8'h11);
    wr(3'd1, 8'hBB); rd(3'd1, v); check("R2 control readback no start", v, 8'h18);
    wr(3'd6, 8'hFF); rd(3'd6, v); check("R2 unused offset", v, 8'h00);
    wr(3'd5, 8'h00);

    // R3 busy bit not writable
    wr(3'd0, 8'h01); rd(3'd0, v); check("R3 busy bit write ignored", v, 8'h00);

    // R11 bad protocol code
    n_start = 0;
    wr(3'd1, 8'h40 | (8'd3 << 2));
    rd(3'd0, v); check("R11 bad code status", v, 8'h10);
    repeat (40) @(negedge clk);
    check("R11 no bus activity", n_start, 0);
    wr(3'd0, 8'h10); rd(3'd0, v); check("R11 cleared", v, 8'h00);

    // directed protocols and R13 SCL high time
    run_op(2, SLV, 8'h10, 8'h77);
    check("R13 SCL high width ns", int'(hi_len), 2 * QDIV * 8);
    run_op(3, SLV, 8'h10, 8'h00);
    run_op(0, SLV, 8'h20, 8'h00);
    run_op(1, SLV, 8'h99, 8'h00);

    // R12 start and writes while busy
    n_start = 0;
    wr(3'd2, {SLV, 1'b0}); wr(3'd3, 8'h44); wr(3'd4, 8'h55);
    wr(3'd1, 8'h40 | (8'd2 << 2));
    rd(3'd0, v); check("R3 busy during transaction", v[0], 1'b1);
    wr(3'd3, 8'hEE);
    wr(3'd1, 8'h40 | (8'd1 << 2));
    rd(3'd3, v); check("R12 command write ignored", v, 8'h44);
    rd(3'd1, v); check("R12 control write ignored", v, 8'h08);
    wait_idle();
    exp_ptr = 8'h44; exp_mem[8'h44] = 8'h55;
    check("R12 second start ignored", n_start, 1);
    check("R6 write while busy test data", slv_mem[8'h44], 8'h55);
    wr(3'd0, 8'h1E);

    // R8 W1C selectivity
    run_op(0, SLV, 8'h30, 8'h00);
    wr(3'd2, {SLV, 1'b0}); wr(3'd1, 8'h40 | (8'd1 << 2)); wait_idle();
    exp_ptr = 8'h30;
    wr(3'd0, 8'h1C); rd(3'd0, v); check("R8 clear of other bits keeps done", v, 8'h02);
    wr(3'd0, 8'h02); rd(3'd0, v); check("R8 done cleared", v, 8'h00);

    // R10 timeout
    wr(3'd5, 8'd5);
    wr(3'd2, {SLV, 1'b0}); wr(3'd3, 8'h01); wr(3'd4, 8'h02);
    wr(3'd1, 8'h40 | (8'd2 << 2));
    wait_idle();
    rd(3'd0, v); check("R10 timeout status", v, 8'h08);
    @(negedge clk);
    check("R10 lines released", {scl_low, sda_low}, 2'b00);
    wr(3'd0, 8'h08); wr(3'd5, 8'd0);

    // random mix, including wrong addresses (R9)
    for (int n = 0; n < 24; n++) begin
      int k;
      logic [6:0] a;
      k = int'($urandom % 4);
      a = (($urandom % 6) == 0) ? 7'h21 : SLV;
      run_op(k, a, 8'($urandom), 8'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule